// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire bus. It frees a bus that a target has left holding the data line low, for instance after a transfer was cut off, after a power loss, or after a reset. A single-cycle trigger starts a bounded clock-out. The block pulls the clock line low and then releases it, repeating this for up to nine pulses, and keeps the data line released the whole time. At the end of every clock-high phase it samples the data line through a synchronizer. The first time it finds the line high, it stops clocking and drives a start condition followed by a stop condition, so the bus is left idle and framed. It then raises a done flag.

If the data line is still low after the ninth pulse, the block releases both lines and raises a failure flag. Both lines are open-drain: each output is an enable that means "pull low". The duration of every bus phase is a cycle count that the block derives from the system clock frequency and from nanosecond timing parameters. The parameter defaults meet standard-mode timing at 50 MHz. There is no data path, so the only interfaces are plain control and status pins.

Top module: `bus_recovery`

## Requirements
- R1: Out of reset both line enables are 0 (lines released) and `busy_o`, `done_o` and `fail_o` are 0.
- R2: The data-line enable stays 0 from the trigger until the data line has been sampled high at the end of a clock-high phase. It is never raised while the clock line is pulled low.
- R3: One sequence produces at most MAX_PULSES (9) clock-low pulses before the start condition or the failure.
- R4: Clocking ends after the first clock-high phase whose closing sample of the data line reads 1. A target that releases the line at its k-th clock rise (k ≤ 9) therefore sees max(k,1) pulses.
- R5: The start condition is the data-line enable rising while the clock line is released. The clock line must have been released for at least the start-setup count before that rise. The clock line is pulled low exactly the start-hold count after it.
- R6: After the start, the clock line is pulled low for one low phase with the data line held low. It is then released. The data-line enable falls exactly the stop-setup count after the clock release. After that, both lines stay released for exactly the bus-free count, and then `done_o` rises.
- R7: `done_o` stays 1, with both lines released, until the next trigger.
- R8: During a sequence, every clock-low phase lasts exactly the low count. Every clock-high phase during clocking lasts exactly the high count.
- R9: A trigger that arrives while `busy_o` is 1 is ignored and does not restart the pulse count.
- R10: If the sample after the last allowed pulse still reads 0, `fail_o` goes to 1 with both lines released and the data line never driven. It stays 1 until the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle trigger for a recovery sequence |
| sda_i | input | 1 | Sensed level of the data line (asynchronous) |
| scl_oe_o | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last sequence freed the bus |
| fail_o | output | 1 | Last sequence found the data line stuck low |

## Verification
The assertions assume that `sda_i` follows the wired level of the bus. That level includes the block's own pull, so the data line reads low whenever `sda_oe_o` is 1. They also assume that a target changes the line only while the clock is held low, or at a clock rise. The stimulus keeps within these limits through a target model. The model counts clock rises and holds the data line low until a random count, drawn between 0 and 12, is reached. Its output is combined with the block's own pull. Directed runs cover release before any clock, release on the ninth rise, a line that never releases, and a trigger issued mid-sequence.

// File: rtl/bus_recovery_pkg.sv
package bus_recovery_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLK_LO,
    ST_CLK_HI,
    ST_STA_SU,
    ST_STA_HD,
    ST_STO_LO,
    ST_STO_SU,
    ST_STO_BUF,
    ST_DONE,
    ST_FAIL
  } rec_state_e;

  function automatic int ns_to_cycles(longint unsigned hz, longint unsigned ns);
    longint unsigned c;
    c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/bus_recovery_timer.sv
module bus_recovery_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R8: a loaded phase starts from exactly the requested count
  a_r8_load_exact: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/bus_recovery_fsm.sv
module bus_recovery_fsm
  import bus_recovery_pkg::*;
#(
  parameter int TW          = 8,
  parameter int MAX_PULSES  = 9,
  parameter int LOW_CYC     = 235,
  parameter int HIGH_CYC    = 200,
  parameter int SU_STA_CYC  = 235,
  parameter int HD_STA_CYC  = 200,
  parameter int SU_STO_CYC  = 235,
  parameter int BUF_CYC     = 235
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          sda_sync_i,
  input  logic          expired_i,
  output logic          load_o,
  output logic [TW-1:0] load_val_o,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o
);
  localparam int PW = $clog2(MAX_PULSES + 1);

  rec_state_e    state_q, state_d;
  logic [PW-1:0] pulse_q, pulse_d;

  function automatic logic [TW-1:0] phase_len(rec_state_e s);
    int n;
    case (s)
      ST_CLK_LO, ST_STO_LO: n = LOW_CYC;
      ST_CLK_HI:            n = HIGH_CYC;
      ST_STA_SU:            n = SU_STA_CYC;
      ST_STA_HD:            n = HD_STA_CYC;
      ST_STO_SU:            n = SU_STO_CYC;
      ST_STO_BUF:           n = BUF_CYC;
      default:              n = 1;
    endcase
    return TW'(n - 1);
  endfunction

  always_comb begin
    state_d = state_q;
    pulse_d = pulse_q;
    case (state_q)
      ST_IDLE, ST_DONE, ST_FAIL:
        if (start_i) begin
          state_d = ST_CLK_LO;
          pulse_d = PW'(1);
        end
      ST_CLK_LO: if (expired_i) state_d = ST_CLK_HI;
      ST_CLK_HI:
        if (expired_i) begin
          if (sda_sync_i)                      state_d = ST_STA_SU;
          else if (pulse_q == PW'(MAX_PULSES)) state_d = ST_FAIL;
          else begin
            state_d = ST_CLK_LO;
            pulse_d = pulse_q + 1'b1;
          end
        end
      ST_STA_SU:  if (expired_i) state_d = ST_STA_HD;
      ST_STA_HD:  if (expired_i) state_d = ST_STO_LO;
      ST_STO_LO:  if (expired_i) state_d = ST_STO_SU;
      ST_STO_SU:  if (expired_i) state_d = ST_STO_BUF;
      ST_STO_BUF: if (expired_i) state_d = ST_DONE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pulse_q <= '0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
    end
  end

  assign load_o     = (state_d != state_q);
  assign load_val_o = phase_len(state_d);
  assign scl_oe_o   = (state_q == ST_CLK_LO) || (state_q == ST_STO_LO);
  assign sda_oe_o   = (state_q == ST_STA_HD) || (state_q == ST_STO_LO) ||
                      (state_q == ST_STO_SU);
  assign busy_o     = !(state_q inside {ST_IDLE, ST_DONE, ST_FAIL});
  assign done_o     = (state_q == ST_DONE);
  assign fail_o     = (state_q == ST_FAIL);

  // R3: pulse count never passes the bound
  a_r3_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q <= PW'(MAX_PULSES));
  // R2/R5: data line is only pulled with the clock released, after a high sample
  a_r5_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_oe_o && $past(sda_sync_i));
  // R6: stop edge happens with the clock released
  a_r6_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> !scl_oe_o);
  // R7: done holds until a new trigger
  a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o && !scl_oe_o && !sda_oe_o);
  // R10: failure only after the last pulse with the line still low
  a_r10_fail_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> !$past(sda_sync_i) && pulse_q == PW'(MAX_PULSES));
  // R9: a trigger while busy does not rewind the pulse count
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> pulse_q >= $past(pulse_q));
endmodule

// File: rtl/bus_recovery.sv
module bus_recovery
  import bus_recovery_pkg::*;
#(
  parameter longint unsigned CLK_HZ     = 50_000_000,
  parameter int              MAX_PULSES = 9,
  parameter int              SYNC_STAGES = 2,
  parameter longint unsigned T_LOW_NS    = 4700,
  parameter longint unsigned T_HIGH_NS   = 4000,
  parameter longint unsigned T_SU_STA_NS = 4700,
  parameter longint unsigned T_HD_STA_NS = 4000,
  parameter longint unsigned T_SU_STO_NS = 4700,
  parameter longint unsigned T_BUF_NS    = 4700
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic sda_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_o
);
  localparam int LOW_CYC    = ns_to_cycles(CLK_HZ, T_LOW_NS);
  localparam int HIGH_CYC   = ns_to_cycles(CLK_HZ, T_HIGH_NS);
  localparam int SU_STA_CYC = ns_to_cycles(CLK_HZ, T_SU_STA_NS);
  localparam int HD_STA_CYC = ns_to_cycles(CLK_HZ, T_HD_STA_NS);
  localparam int SU_STO_CYC = ns_to_cycles(CLK_HZ, T_SU_STO_NS);
  localparam int BUF_CYC    = ns_to_cycles(CLK_HZ, T_BUF_NS);
  localparam int MAX_A = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int MAX_B = (SU_STA_CYC > HD_STA_CYC) ? SU_STA_CYC : HD_STA_CYC;
  localparam int MAX_C = (SU_STO_CYC > BUF_CYC) ? SU_STO_CYC : BUF_CYC;
  localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_ALL = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int TW = $clog2(MAX_ALL + 1);

  logic          sda_sync;
  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign sda_sync = sda_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], sda_i};
      end
      assign sda_sync = chain_q[SYNC_STAGES-1];
    end
  endgenerate

  bus_recovery_timer #(.TW(TW)) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  bus_recovery_fsm #(
    .TW         (TW),
    .MAX_PULSES (MAX_PULSES),
    .LOW_CYC    (LOW_CYC),
    .HIGH_CYC   (HIGH_CYC),
    .SU_STA_CYC (SU_STA_CYC),
    .HD_STA_CYC (HD_STA_CYC),
    .SU_STO_CYC (SU_STO_CYC),
    .BUF_CYC    (BUF_CYC)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .sda_sync_i (sda_sync),
    .expired_i  (tmr_expired),
    .load_o     (tmr_load),
    .load_val_o (tmr_val),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_o     (fail_o)
  );

  // R2: while the clock is pulled low the data line is not being newly pulled
  a_r2_no_sda_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe_o) && !$past(sda_oe_o) |-> !sda_oe_o);
endmodule

// File: tb/bus_recovery_tb_top.sv
module bus_recovery_tb_top;
  localparam int LOW = 235, HIGH = 200, SU_STA = 235, HD_STA = 200,
                 SU_STO = 235, BUFC = 235, MAXP = 9;

  logic clk = 0, rst_n = 0, start_i = 0;
  logic scl_oe_o, sda_oe_o, busy_o, done_o, fail_o;
  int   hold_n = 0;
  int   rises = 0;
  logic sda_w;
  int   checks = 0, fails = 0;
  bit   finished = 0;

  always #10 clk = ~clk;

  assign sda_w = !sda_oe_o && (rises >= hold_n);

  bus_recovery dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sda_i(sda_w),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .busy_o(busy_o),
    .done_o(done_o), .fail_o(fail_o));

  // monitor state
  longint cyc = 0, t_fall = 0, t_rise = 0, t_on = 0, t_off = 0, t_done = 0;
  int falls = 0, lo_bad = 0, hi_bad = 0, on_cnt = 0, on_bad = 0, off_bad = 0;
  longint hd_len = -1, su_len = 0, sto_len = 0;
  bit have_rise = 0, started = 0;
  logic p_scl = 1, p_oe = 0, p_done = 0;

  always @(negedge clk) begin
    logic scl;
    cyc++;
    scl = !scl_oe_o;
    if (p_scl && !scl) begin
      falls++;
      if (have_rise && !started && (cyc - t_rise) != HIGH) hi_bad++;
      if (started && hd_len < 0) hd_len = cyc - t_on;
      t_fall = cyc;
    end
    if (!p_scl && scl) begin
      rises++;
      have_rise = 1;
      if ((cyc - t_fall) != LOW) lo_bad++;
      t_rise = cyc;
    end
    if (!p_oe && sda_oe_o) begin
      on_cnt++;
      if (!scl) on_bad++;
      started = 1;
      t_on = cyc;
      su_len = cyc - t_rise;
    end
    if (p_oe && !sda_oe_o) begin
      t_off = cyc;
      sto_len = cyc - t_rise;
      if (!scl) off_bad++;
    end
    if (!p_done && done_o) t_done = cyc;
    p_scl = scl; p_oe = sda_oe_o; p_done = done_o;
  end

  function automatic int exp_falls(int n);
    if (n <= MAXP) return ((n < 1) ? 1 : n) + 1;
    return MAXP;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic run(input int n, input bit poke);
    bit ok_exp;
    int guard;
    @(posedge clk); #1;
    hold_n = n; rises = 0; falls = 0; lo_bad = 0; hi_bad = 0; on_cnt = 0;
    on_bad = 0; off_bad = 0; hd_len = -1; have_rise = 0; started = 0;
    start_i = 1;
    @(posedge clk); #1;
    start_i = 0;
    chk(busy_o && !done_o && !fail_o, "R7 flags clear on trigger", busy_o, 1);
    if (poke) begin
      repeat (1000) @(posedge clk);
      #1 start_i = 1;
      @(posedge clk); #1 start_i = 0;
    end
    guard = 0;
    while (!(done_o || fail_o) && guard < 20000) begin
      @(posedge clk); #1; guard++;
    end
    @(posedge clk); #1;
    ok_exp = (n <= MAXP);
    chk(done_o == ok_exp, ok_exp ? "R4 done" : "R10 no done", done_o, ok_exp);
    chk(fail_o == !ok_exp, "R10 fail flag", fail_o, !ok_exp);
    chk(falls == exp_falls(n), poke ? "R9 pulse count after mid trigger" : "R3 pulse count",
        falls, exp_falls(n));
    chk(lo_bad == 0 && hi_bad == 0, "R8 phase lengths", lo_bad + hi_bad, 0);
    chk(on_cnt == (ok_exp ? 1 : 0) && on_bad == 0, "R2 data drive count", on_cnt, ok_exp ? 1 : 0);
    chk(!scl_oe_o && !sda_oe_o, "R7 lines released", {scl_oe_o, sda_oe_o}, 0);
    if (ok_exp) begin
      chk(su_len >= SU_STA, "R5 start setup", su_len, SU_STA);
      chk(hd_len == HD_STA, "R5 start hold", hd_len, HD_STA);
      chk(sto_len == SU_STO && off_bad == 0, "R6 stop setup", sto_len, SU_STO);
      chk((t_done - t_off) == BUFC, "R6 bus free", t_done - t_off, BUFC);
    end
    repeat (40) @(posedge clk);
    #1;
    chk(done_o == ok_exp && fail_o == !ok_exp && !busy_o, "R7 status held",
        {done_o, fail_o}, ok_exp ? 2 : 1);
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(posedge clk);
    #1;
    chk(!scl_oe_o && !sda_oe_o && !busy_o && !done_o && !fail_o, "R1 reset state",
        {scl_oe_o, sda_oe_o, busy_o, done_o, fail_o}, 0);
    rst_n = 1;
    repeat (2) @(posedge clk);
    run(0, 0);
    run(MAXP, 0);
    run(MAXP + 1, 0);
    run(3, 1);
    for (int i = 0; i < 12; i++) run(int'($urandom_range(0, 12)), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule